// File: doc/BRIEF.md
# Windowless Software Watchdog Counter

This block is a free-running supervisor for embedded software. A 7-bit counter counts down by one on every prescaled tick once software has switched it on. Software keeps it alive by writing the control register before the counter's top bit drops. Each write loads a new count. If the counter's most significant bit ever goes from 1 to 0 while the watchdog is on, the block requests a system reset. That 1-to-0 change can come from a tick or from a careless write. The request is a pulse of fixed length.

Once set, the on bit cannot be cleared by software; only the block's own reset clears it. After it has fired, the counter stays frozen until that reset. A sticky flag records that a watchdog reset happened. Software clears the flag by reading the status register. The flag survives the system reset, which lets boot code tell why the chip restarted.

Top module: `wdog_guard`

## Requirements
- R1: After reset the control register reads 7Fh (off, count all ones), the status register reads 00h, and `rst_req` and `rst_flag` are 0.
- R2: Register map: `addr`=0 is control, where bit 7 is the on bit and bits 6:0 are the count. `addr`=1 is status, where bit 0 is the watchdog-reset flag and bits 7:1 read 0. Writes to `addr`=1 have no effect.
- R3: While off, ticks do not change the count, and writes with bit 7 = 0 never raise `rst_req`. This holds even when the write clears count bit 6.
- R4: While on, each cycle with `tick`=1 and no control write lowers the count by one. Cycles without `tick` leave it unchanged.
- R5: A control write loads data bits 6:0 into the count in the next cycle, and this write takes priority over a tick in the same cycle.
- R6: Writing bit 7 = 1 sets the on bit. A later write with bit 7 = 0 leaves it set.
- R7: While on, a tick that takes the count from 40h to 3Fh raises `rst_req` in the following cycle. `rst_req` stays high for exactly 16 cycles.
- R8: A control write that turns the watchdog on, or one made while it is on, raises `rst_req` in the next cycle if it changes count bit 6 from 1 to 0.
- R9: After the watchdog fires, the count is frozen and control writes and ticks are ignored until the block is reset. The control register keeps reading the value reached at the firing.
- R10: Firing sets `rst_flag` and status bit 0. The flag stays set after the pulse ends and is not cleared by reading control. A read of `addr`=1 with `rd_en`=1 clears it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag when it reads status) |
| addr | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Prescaled count-enable pulse |
| rd_data | output | 8 | Read data for the selected register |
| rst_req | output | 1 | System reset request pulse |
| rst_flag | output | 1 | Sticky watchdog-reset flag |

## Verification
The bench targets the exact firing point: the tick that takes the count from 40h to 3Fh. A design that fires on terminal count zero instead would stay silent there. It checks that a write which drops bit 6 fires at once, while the same write with the watchdog off does not. An off-state check would miss the first case, and a design without one would fail the second. The pulse width is counted to the cycle. After firing, the bench tries writes and ticks to show the count is frozen, which would catch a design that lets software restart a tripped watchdog. It also checks that reading control leaves the flag alone while reading status clears it.

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int CNT_W     = 7,
  parameter int PULSE_LEN = 16,
  localparam int DW       = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tick,
  output logic [DW-1:0] rd_data,
  output logic          rst_req,
  output logic          rst_flag
);
  localparam int TOP = CNT_W - 1;
  localparam int PW  = $clog2(PULSE_LEN + 1);

  logic             act, act_nx, tripped, fire, flag;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [PW-1:0]    pcnt;

  always_comb begin
    act_nx = act;
    cnt_nx = cnt;
    if (!tripped) begin
      if (wr_en && !addr) begin
        act_nx = act | wr_data[DW-1];
        cnt_nx = wr_data[CNT_W-1:0];
      end else if (act && tick) begin
        cnt_nx = cnt - 1'b1;
      end
    end
  end

  assign fire = !tripped && act_nx && cnt[TOP] && !cnt_nx[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      cnt     <= '1;
      tripped <= 1'b0;
      pcnt    <= '0;
      flag    <= 1'b0;
    end else begin
      act <= act_nx;
      cnt <= cnt_nx;
      if (fire) begin
        tripped <= 1'b1;
        pcnt    <= PW'(PULSE_LEN);
      end else if (pcnt != '0) begin
        pcnt <= pcnt - 1'b1;
      end
      if (fire)
        flag <= 1'b1;
      else if (rd_en && addr)
        flag <= 1'b0;
    end
  end

  assign rst_req  = (pcnt != '0);
  assign rst_flag = flag;
  assign rd_data  = addr ? {{(DW-1){1'b0}}, flag} : {act, cnt};

  a_r6_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> act);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !(wr_en && !addr && wr_data[DW-1]) && !rst_req) |=> !rst_req);

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !tripped && tick && !wr_en) |=> (cnt == $past(cnt) - 1'b1));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |=> $stable(cnt) && tripped);

  a_r10_flag_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> rst_flag);

  a_r7_req_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> tripped);
endmodule

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rst_req, rst_flag;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  wdog_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .tick(tick), .rd_data(rd_data),
    .rst_req(rst_req), .rst_flag(rst_flag)
  );

  // {wr_en, tick, wr_data, expected control readback}
  localparam logic [17:0] VEC [9] = '{
    {1'b1, 1'b0, 8'h55, 8'h55},
    {1'b0, 1'b1, 8'h00, 8'h55},
    {1'b1, 1'b0, 8'hE0, 8'hE0},
    {1'b0, 1'b1, 8'h00, 8'hDF},
    {1'b0, 1'b1, 8'h00, 8'hDE},
    {1'b0, 1'b0, 8'h00, 8'hDE},
    {1'b1, 1'b0, 8'h7A, 8'hFA},
    {1'b1, 1'b1, 8'hC3, 8'hC3},
    {1'b0, 1'b1, 8'h00, 8'hC2}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic a, input logic [7:0] d,
                      input logic t, input logic r);
    wr_en = w; addr = a; wr_data = d; tick = t; rd_en = r;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; rd_en = 1'b0; addr = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int highs;
    do_reset();
    addr = 1'b0; #1;
    chk("R1 ctrl", rd_data, 8'h7F);
    addr = 1'b1; #1;
    chk("R1 status", rd_data, 8'h00);
    chk("R1 req/flag", {6'd0, rst_req, rst_flag}, 8'h00);
    addr = 1'b0;

    for (int i = 0; i < 9; i++) begin
      step(VEC[i][17], 1'b0, VEC[i][15:8], VEC[i][16], 1'b0);
      #1;
      chk($sformatf("R4/R5/R6 vec%0d", i), rd_data, VEC[i][7:0]);
      chk($sformatf("R3 no req vec%0d", i), {7'd0, rst_req}, 8'h00);
    end

    step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
    #1;
    chk("R2 status write ignored", rd_data, 8'hC2);

    step(1'b1, 1'b0, 8'hC1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    #1;
    chk("R7 at 40h", rd_data, 8'hC0);
    chk("R7 no early req", {7'd0, rst_req}, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    #1;
    chk("R7 req raised", {7'd0, rst_req}, 8'h01);
    chk("R9 frozen value", rd_data, 8'hBF);
    chk("R10 flag set", {7'd0, rst_flag}, 8'h01);
    highs = 1;
    for (int k = 0; k < 20; k++) begin
      if (k == 2) step(1'b1, 1'b0, 8'hFF, 1'b0, 1'b0);
      else        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      if (rst_req) highs++;
    end
    chk("R7 pulse length", 8'(highs), 8'd16);
    #1;
    chk("R9 ignores write/tick", rd_data, 8'hBF);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R10 ctrl read keeps flag", {7'd0, rst_flag}, 8'h01);
    addr = 1'b1; #1;
    chk("R10 status bit0", rd_data, 8'h01);
    step(1'b0, 1'b1, 8'h00, 1'b0, 1'b1);
    addr = 1'b1; #1;
    chk("R10 flag cleared", rd_data, 8'h00);
    addr = 1'b0;

    do_reset();
    #1;
    chk("R1 after reset", rd_data, 8'h7F);
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    #1;
    chk("R3 off write drops bit6", {7'd0, rst_req}, 8'h00);
    chk("R3 off loaded", rd_data, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    #1;
    chk("R3 off tick", rd_data, 8'h00);

    do_reset();
    step(1'b1, 1'b0, 8'h80, 1'b0, 1'b0);
    #1;
    chk("R8 activating write", {7'd0, rst_req}, 8'h01);

    do_reset();
    step(1'b1, 1'b0, 8'hFF, 1'b0, 1'b0);
    #1;
    chk("R8 no req yet", {7'd0, rst_req}, 8'h00);
    step(1'b1, 1'b0, 8'h3F, 1'b0, 1'b0);
    #1;
    chk("R8 write drops bit6", {7'd0, rst_req}, 8'h01);
    chk("R8 ctrl", rd_data, 8'hBF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule